// File: doc/BRIEF.md
# LPC Memory Cycle Target Engine

This block is the target side of a Low Pin Count memory cycle. It watches the four-bit multiplexed bus together with the frame strobe and a chip-select input. It recognises a valid start condition and decodes the cycle type. It then gathers a 32-bit address and either collects a write byte or returns a read byte. On reads it owns the bus only for the turnaround, sync and data clocks it is responsible for, and it gives the bus back to the host afterwards.

Toward the back end the block presents the assembled address and a one-clock write strobe with its byte. For reads it raises a request and holds it until the back end returns a byte with a ready flag. The address is qualified through an input hook: when the back end reports the address as not its own, the cycle is dropped silently. The engine has two active-low reset inputs that act as one. Either input clears the engine at once, and the engine leaves reset on the clock.

Top module: `lpc_mem_target`

## Requirements
- R1: Driving either `rst_a_n` or `rst_b_n` low forces `lad_oe`, `be_rd_req` and `be_wr_stb` low at once, without waiting for a clock edge. After both inputs are high again, the engine leaves reset within two clocks.
- R2: The start nibble is the value sampled on the last rising edge at which `frame_n` is low. The host may hold `frame_n` low for several clocks and change the nibble during that time. A cycle begins only when that last nibble is 0000.
- R3: A cycle is accepted only if `cs_n` was sampled low on the edge just before the last frame-low edge. Otherwise the engine never drives the bus, never requests a read and never strobes a write.
- R4: On the first edge after the start, with `frame_n` high, the nibble 0100 selects a memory read and 0110 selects a memory write. Any other type value sends the engine back to idle without further effect.
- R5: Eight address nibbles follow the type, most significant nibble first. Once the eighth nibble is taken, `be_addr` holds the full 32-bit address.
- R6: On a write, two data nibbles follow the address directly, low nibble first. `be_wr_stb` is high for exactly the one clock after the high nibble is sampled, with `be_wr_data` holding the byte. Two undriven turnaround clocks then end the cycle.
- R7: On a read, the target leaves the bus undriven for the first turnaround clock after the address. It then drives 1111 for one clock.
- R8: After the turnaround, the target drives sync 0101 while the byte is outstanding and 0000 once the byte is held. It then drives the low data nibble, then the high one, then 1111 for one clock, and then releases the bus.
- R9: The target drives at most `MAX_WAIT` clocks of 0101. If the byte is still missing at that point, it drives 1010 for one clock, then 1111, and then releases the bus with no data. A byte that arrives on the last allowed wait clock is still accepted.
- R10: When `frame_n` is sampled low in the middle of a cycle, the cycle is aborted. `lad_oe` is low from the next clock on, and an unfinished write never strobes.
- R11: If `be_addr_ok` is low once the address is complete, the cycle is ignored. There is no read request, no bus drive and no write strobe.
- R12: `be_rd_req` is high from the first turnaround clock of a qualified read until the clock after the back end's `be_rd_ready` is sampled together with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_a_n | input | 1 | Active-low reset, first source |
| rst_b_n | input | 1 | Active-low reset, second source |
| cs_n | input | 1 | Active-low chip select |
| frame_n | input | 1 | Active-low frame strobe from the host |
| lad_in | input | 4 | Sampled value of the multiplexed bus |
| lad_out | output | 4 | Nibble driven by the target |
| lad_oe | output | 1 | Target drive enable for the bus |
| be_addr | output | 32 | Assembled cycle address |
| be_addr_ok | input | 1 | Back-end verdict that the address belongs to it |
| be_wr_stb | output | 1 | One-clock write strobe |
| be_wr_data | output | 8 | Write byte |
| be_rd_req | output | 1 | Read byte request |
| be_rd_ready | input | 1 | Read byte valid from the back end |
| be_rd_data | input | 8 | Read byte from the back end |

## Verification
The wait limit and the arrival of the read byte can both resolve on the same edge, when the ready flag is first seen on the last allowed wait clock. The scoreboard sweeps the ready delay across that edge. A delay of exactly the limit must give a 0000 sync followed by data, and one more clock must give 1010 and no data. A second collision is a frame abort on an edge where the target is driving sync. The expected result there is an undriven bus on the following clock, with the read request already low.

// File: rtl/lpc_tgt_pkg.sv
package lpc_tgt_pkg;

  localparam int NIB_W = 4;
  typedef logic [NIB_W-1:0] nib_t;

  localparam nib_t NIB_START = 4'h0;
  localparam nib_t TYP_MRD   = 4'h4;
  localparam nib_t TYP_MWR   = 4'h6;
  localparam nib_t SYN_WAIT  = 4'h5;
  localparam nib_t SYN_RDY   = 4'h0;
  localparam nib_t SYN_ERR   = 4'hA;
  localparam nib_t NIB_TAR   = 4'hF;

  typedef enum logic [3:0] {
    S_IDLE,
    S_FRAME,
    S_ADDR,
    S_WLO,
    S_WHI,
    S_TW0,
    S_TW1,
    S_TAKE0,
    S_TAKE1,
    S_WAIT,
    S_SOK,
    S_SERR,
    S_DLO,
    S_DHI,
    S_GIVE0,
    S_GIVE1
  } tst_e;

endpackage

// File: rtl/lpc_rst_join.sv
module lpc_rst_join #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_a_n,
  input  logic rst_b_n,
  output logic rst_n_o
);

  logic arst_n;
  assign arst_n = rst_a_n & rst_b_n;

  for (genvar gi = 0; gi < STAGES; gi++) begin : g_stg
    logic q;
    if (gi == 0) begin : g_head
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) q <= 1'b0;
        else         q <= 1'b1;
      end
    end else begin : g_tail
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) q <= 1'b0;
        else         q <= g_stg[gi-1].q;
      end
    end
  end

  assign rst_n_o = g_stg[STAGES-1].q;

  // R1: either source low keeps the joined reset asserted
  p_join_hold_r1: assert property (@(posedge clk)
    (!rst_a_n || !rst_b_n) |-> !rst_n_o);

endmodule

// File: rtl/lpc_frame_track.sv
module lpc_frame_track
  import lpc_tgt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic frame_n,
  input  logic cs_n,
  input  nib_t lad_in,
  output logic start_go
);

  logic cs_q;
  logic frame_lo_q;
  logic sel_q;
  nib_t st_nib_q;

  // chip select seen on the previous edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cs_q <= 1'b1;
    else        cs_q <= cs_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frame_lo_q <= 1'b0;
    else        frame_lo_q <= !frame_n;
  end

  // latch start nibble and selection on every frame-low edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_nib_q <= NIB_TAR;
      sel_q    <= 1'b0;
    end else if (!frame_n) begin
      st_nib_q <= lad_in;
      sel_q    <= !cs_q;
    end
  end

  assign start_go = frame_lo_q && frame_n && (st_nib_q == NIB_START) && sel_q;

endmodule

// File: rtl/lpc_addr_col.sv
module lpc_addr_col #(
  parameter int ADDR_W = 32,
  parameter int NIB_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              shift_en,
  input  logic [NIB_W-1:0]  nib,
  output logic [ADDR_W-1:0] addr,
  output logic              last
);

  localparam int NIBS = ADDR_W / NIB_W;
  localparam int CW   = $clog2(NIBS + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (clr)      cnt_q <= '0;
    else if (shift_en) cnt_q <= cnt_q + 1'b1;
  end

  assign last = shift_en && (cnt_q == CW'(NIBS - 1));

  // one nibble slot per position; slot 0 takes the newest nibble
  for (genvar gi = 0; gi < NIBS; gi++) begin : g_slot
    logic [NIB_W-1:0] q;
    if (gi == 0) begin : g_in
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        q <= '0;
        else if (shift_en) q <= nib;
      end
    end else begin : g_mv
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        q <= '0;
        else if (shift_en) q <= g_slot[gi-1].q;
      end
    end
    assign addr[gi*NIB_W +: NIB_W] = q;
  end

endmodule

// File: rtl/lpc_tgt_fsm.sv
module lpc_tgt_fsm
  import lpc_tgt_pkg::*;
#(
  parameter int MAX_WAIT = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_n,
  input  nib_t       lad_in,
  input  logic       start_go,
  input  logic       addr_last,
  input  logic       addr_ok,
  input  logic       rd_ready,
  input  logic [7:0] rd_data,
  output logic       addr_shift,
  output nib_t       lad_out,
  output logic       lad_oe,
  output logic       wr_stb,
  output logic [7:0] wr_data,
  output logic       rd_req
);

  localparam int WCW = $clog2(MAX_WAIT + 1);

  tst_e           st_q, st_d;
  logic           rd_q, rd_d;
  logic           have_q;
  logic [7:0]     rbyte_q;
  logic [7:0]     wbyte_q;
  logic [WCW-1:0] wcnt_q, wcnt_d;
  logic           rd_take;
  logic           wlo_en, whi_en;

  assign rd_take = rd_req && rd_ready;

  // next state
  always_comb begin
    st_d = st_q;
    rd_d = rd_q;
    if (!frame_n) begin
      st_d = S_FRAME;
    end else begin
      case (st_q)
        S_IDLE, S_FRAME: begin
          st_d = S_IDLE;
          if (start_go) begin
            if (lad_in == TYP_MRD) begin
              st_d = S_ADDR;
              rd_d = 1'b1;
            end else if (lad_in == TYP_MWR) begin
              st_d = S_ADDR;
              rd_d = 1'b0;
            end
          end
        end
        S_ADDR:  if (addr_last) st_d = rd_q ? S_TAKE0 : S_WLO;
        S_WLO:   st_d = addr_ok ? S_WHI : S_IDLE;
        S_WHI:   st_d = S_TW0;
        S_TW0:   st_d = S_TW1;
        S_TW1:   st_d = S_IDLE;
        S_TAKE0: st_d = addr_ok ? S_TAKE1 : S_IDLE;
        S_TAKE1: st_d = (have_q || rd_take) ? S_SOK : S_WAIT;
        S_WAIT: begin
          if (rd_ready)                          st_d = S_SOK;
          else if (wcnt_q == WCW'(MAX_WAIT - 1)) st_d = S_SERR;
        end
        S_SOK:   st_d = S_DLO;
        S_SERR:  st_d = S_GIVE0;
        S_DLO:   st_d = S_DHI;
        S_DHI:   st_d = S_GIVE0;
        S_GIVE0: st_d = S_GIVE1;
        S_GIVE1: st_d = S_IDLE;
        default: st_d = S_IDLE;
      endcase
    end
  end

  always_comb begin
    wcnt_d = '0;
    if (st_q == S_WAIT) wcnt_d = wcnt_q + 1'b1;
  end

  assign wlo_en     = (st_q == S_WLO) && frame_n && addr_ok;
  assign whi_en     = (st_q == S_WHI) && frame_n;
  assign addr_shift = (st_q == S_ADDR) && frame_n;

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      rd_q   <= 1'b0;
      wcnt_q <= '0;
    end else begin
      st_q   <= st_d;
      rd_q   <= rd_d;
      wcnt_q <= wcnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               have_q <= 1'b0;
    else if (st_d == S_ADDR)  have_q <= 1'b0;
    else if (rd_take)         have_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rbyte_q <= '0;
    else if (rd_take) rbyte_q <= rd_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbyte_q <= '0;
    end else begin
      if (wlo_en) wbyte_q[3:0] <= lad_in;
      if (whi_en) wbyte_q[7:4] <= lad_in;
    end
  end

  // outputs
  assign lad_oe = st_q inside {S_TAKE1, S_WAIT, S_SOK, S_SERR, S_DLO, S_DHI, S_GIVE0};

  always_comb begin
    case (st_q)
      S_WAIT:  lad_out = SYN_WAIT;
      S_SOK:   lad_out = SYN_RDY;
      S_SERR:  lad_out = SYN_ERR;
      S_DLO:   lad_out = rbyte_q[3:0];
      S_DHI:   lad_out = rbyte_q[7:4];
      default: lad_out = NIB_TAR;
    endcase
  end

  assign wr_stb  = (st_q == S_TW0);
  assign wr_data = wbyte_q;
  assign rd_req  = (st_q inside {S_TAKE0, S_TAKE1, S_WAIT}) && !have_q && addr_ok;

  // observer for consecutive wait syncs on the bus
  logic [WCW:0] mon_wait_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               mon_wait_q <= '0;
    else if (lad_oe && lad_out == SYN_WAIT) begin
      if (mon_wait_q != '1)                   mon_wait_q <= mon_wait_q + 1'b1;
    end else                                  mon_wait_q <= '0;
  end

  p_wait_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mon_wait_q <= (WCW+1)'(MAX_WAIT));

  p_abort_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_n |=> !lad_oe);

  p_stb_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  p_take_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lad_oe) |-> (lad_out == NIB_TAR));

endmodule

// File: rtl/lpc_mem_target.sv
module lpc_mem_target
  import lpc_tgt_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int MAX_WAIT   = 8,
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_a_n,
  input  logic              rst_b_n,
  input  logic              cs_n,
  input  logic              frame_n,
  input  logic [3:0]        lad_in,
  output logic [3:0]        lad_out,
  output logic              lad_oe,
  output logic [ADDR_W-1:0] be_addr,
  input  logic              be_addr_ok,
  output logic              be_wr_stb,
  output logic [7:0]        be_wr_data,
  output logic              be_rd_req,
  input  logic              be_rd_ready,
  input  logic [7:0]        be_rd_data
);

  logic rst_n;
  logic start_go;
  logic addr_shift;
  logic addr_last;

  lpc_rst_join #(.STAGES(RST_STAGES)) u_rst (
    .clk     (clk),
    .rst_a_n (rst_a_n),
    .rst_b_n (rst_b_n),
    .rst_n_o (rst_n)
  );

  lpc_frame_track u_frm (
    .clk      (clk),
    .rst_n    (rst_n),
    .frame_n  (frame_n),
    .cs_n     (cs_n),
    .lad_in   (lad_in),
    .start_go (start_go)
  );

  lpc_addr_col #(.ADDR_W(ADDR_W), .NIB_W(NIB_W)) u_adr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (start_go),
    .shift_en (addr_shift),
    .nib      (lad_in),
    .addr     (be_addr),
    .last     (addr_last)
  );

  lpc_tgt_fsm #(.MAX_WAIT(MAX_WAIT)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_n    (frame_n),
    .lad_in     (lad_in),
    .start_go   (start_go),
    .addr_last  (addr_last),
    .addr_ok    (be_addr_ok),
    .rd_ready   (be_rd_ready),
    .rd_data    (be_rd_data),
    .addr_shift (addr_shift),
    .lad_out    (lad_out),
    .lad_oe     (lad_oe),
    .wr_stb     (be_wr_stb),
    .wr_data    (be_wr_data),
    .rd_req     (be_rd_req)
  );

endmodule

// File: tb/lpc_mem_target_tb.sv
module lpc_mem_target_tb;

  localparam int MW = 4;

  logic        clk = 1'b0;
  logic        rst_a_n, rst_b_n, cs_n, frame_n, rdy;
  logic [3:0]  lad_in, lad_out;
  logic        lad_oe, be_wr_stb, be_rd_req, be_addr_ok;
  logic [31:0] be_addr;
  logic [7:0]  be_wr_data, be_rd_data;

  int vecs = 0;
  int fails = 0;

  always #4 clk = ~clk;

  // back-end model: window at the top 1 MByte, data derived from address
  assign be_addr_ok = (be_addr[31:20] == 12'hFFF);
  assign be_rd_data = be_addr[7:0] ^ 8'h3C;

  lpc_mem_target #(.MAX_WAIT(MW)) u_dut (
    .clk(clk), .rst_a_n(rst_a_n), .rst_b_n(rst_b_n), .cs_n(cs_n),
    .frame_n(frame_n), .lad_in(lad_in), .lad_out(lad_out), .lad_oe(lad_oe),
    .be_addr(be_addr), .be_addr_ok(be_addr_ok), .be_wr_stb(be_wr_stb),
    .be_wr_data(be_wr_data), .be_rd_req(be_rd_req), .be_rd_ready(rdy),
    .be_rd_data(be_rd_data)
  );

  typedef struct {
    logic        oe;
    logic [3:0]  lad;
    logic        stb;
    logic [7:0]  wd;
    logic        req;
    logic        chk_addr;
    logic [31:0] addr;
    string       tag;
  } exp_t;

  exp_t q[$];

  function automatic exp_t mk(input logic oe, input logic [3:0] lad, input logic req, input string tag);
    exp_t e;
    e.oe = oe; e.lad = lad; e.stb = 1'b0; e.wd = 8'h00; e.req = req;
    e.chk_addr = 1'b0; e.addr = 32'h0; e.tag = tag;
    return e;
  endfunction

  // driver: one bus clock; the expectation is for the outputs after this edge
  task automatic step(input logic fr, input logic [3:0] nib, input logic ce, input logic rd, input exp_t e);
    @(negedge clk);
    frame_n = fr; lad_in = nib; cs_n = ce; rdy = rd;
    q.push_back(e);
  endtask

  // monitor: compares shortly after each rising edge
  always begin
    @(posedge clk);
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      vecs++;
      if (lad_oe !== e.oe || (e.oe && lad_out !== e.lad) || be_wr_stb !== e.stb ||
          (e.stb && be_wr_data !== e.wd) || be_rd_req !== e.req ||
          (e.chk_addr && be_addr !== e.addr)) begin
        fails++;
        $display("FAIL %s: got oe=%b lad=%h stb=%b wd=%h req=%b addr=%h, expected oe=%b lad=%h stb=%b wd=%h req=%b addr=%h",
                 e.tag, lad_oe, lad_out, be_wr_stb, be_wr_data, be_rd_req, be_addr,
                 e.oe, e.lad, e.stb, e.wd, e.req, e.addr);
      end
    end
  end

  task automatic check_now(input string tag, input logic act, input logic exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b, expected %b", tag, act, exp);
    end
  endtask

  task automatic run_cycle(input logic [3:0] typ, input logic [31:0] a, input logic [7:0] wd,
                           input int frlen, input logic [3:0] lastnib, input bit ce_ok,
                           input int d, input string tag);
    logic c;
    bit acc, rd, ok, have, err;
    int waits;
    logic [7:0] b;
    exp_t e;
    c = ce_ok ? 1'b0 : 1'b1;
    rd = (typ == 4'h4);
    ok = (a[31:20] == 12'hFFF);
    acc = ce_ok && (lastnib == 4'h0) && (typ == 4'h4 || typ == 4'h6);
    b = a[7:0] ^ 8'h3C;
    step(1'b1, 4'hF, c, 1'b0, mk(0, 0, 0, tag));
    for (int i = 0; i < frlen; i++)
      step(1'b0, (i == frlen - 1) ? lastnib : 4'h9, c, 1'b0, mk(0, 0, 0, tag));
    step(1'b1, typ, c, 1'b0, mk(0, 0, 0, tag));
    if (!acc) begin
      for (int i = 0; i < 12; i++) step(1'b1, i[3:0], c, 1'b1, mk(0, 0, 0, tag));
      return;
    end
    for (int i = 0; i < 8; i++) begin
      e = mk(0, 0, 0, tag);
      if (i == 7) begin e.req = rd && ok; e.chk_addr = 1'b1; e.addr = a; end
      step(1'b1, a[31-4*i -: 4], c, 1'b0, e);
    end
    if (!ok) begin
      for (int i = 0; i < 6; i++) step(1'b1, 4'h5, c, 1'b1, mk(0, 0, 0, tag));
      return;
    end
    if (!rd) begin
      step(1'b1, wd[3:0], c, 1'b0, mk(0, 0, 0, tag));
      e = mk(0, 0, 0, tag); e.stb = 1'b1; e.wd = wd;
      step(1'b1, wd[7:4], c, 1'b0, e);
      step(1'b1, 4'hF, c, 1'b0, mk(0, 0, 0, tag));
      step(1'b1, 4'hF, c, 1'b0, mk(0, 0, 0, tag));
      return;
    end
    // read: turnaround, sync, data, final turnaround
    have = (d <= 0);
    err = 1'b0;
    waits = 0;
    step(1'b1, 4'hF, c, have, mk(1, 4'hF, !have, tag));
    if (!have && d <= 1) begin
      have = 1'b1;
      step(1'b1, 4'hF, c, 1'b1, mk(1, 4'h0, 0, tag));
    end else if (have) begin
      step(1'b1, 4'hF, c, 1'b0, mk(1, 4'h0, 0, tag));
    end else begin
      step(1'b1, 4'hF, c, 1'b0, mk(1, 4'h5, 1, tag));
      waits = 1;
      for (int k = 2; k < 1000; k++) begin
        if (k >= d) begin
          step(1'b1, 4'hF, c, 1'b1, mk(1, 4'h0, 0, tag));
          break;
        end else if (waits == MW) begin
          step(1'b1, 4'hF, c, 1'b0, mk(1, 4'hA, 0, tag));
          err = 1'b1;
          break;
        end else begin
          step(1'b1, 4'hF, c, 1'b0, mk(1, 4'h5, 1, tag));
          waits++;
        end
      end
    end
    if (!err) begin
      step(1'b1, 4'hF, c, 1'b0, mk(1, b[3:0], 0, tag));
      step(1'b1, 4'hF, c, 1'b0, mk(1, b[7:4], 0, tag));
    end
    step(1'b1, 4'hF, c, 1'b0, mk(1, 4'hF, 0, tag));
    step(1'b1, 4'hF, c, 1'b0, mk(0, 0, 0, tag));
    step(1'b1, 4'hF, c, 1'b0, mk(0, 0, 0, tag));
  endtask

  // read up to the first wait sync (ready never given)
  task automatic read_to_wait(input logic [31:0] a, input string tag);
    exp_t e;
    step(1'b1, 4'hF, 1'b0, 1'b0, mk(0, 0, 0, tag));
    step(1'b0, 4'h0, 1'b0, 1'b0, mk(0, 0, 0, tag));
    step(1'b1, 4'h4, 1'b0, 1'b0, mk(0, 0, 0, tag));
    for (int i = 0; i < 8; i++) begin
      e = mk(0, 0, 0, tag);
      if (i == 7) e.req = 1'b1;
      step(1'b1, a[31-4*i -: 4], 1'b0, 1'b0, e);
    end
    step(1'b1, 4'hF, 1'b0, 1'b0, mk(1, 4'hF, 1, tag));
    step(1'b1, 4'hF, 1'b0, 1'b0, mk(1, 4'h5, 1, tag));
  endtask

  task automatic drain;
    while (q.size() > 0) @(posedge clk);
    @(posedge clk);
    #3;
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog: got run still active, expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_a_n = 1'b0; rst_b_n = 1'b1; cs_n = 1'b1; frame_n = 1'b1; lad_in = 4'hF; rdy = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check_now("R1 reset oe", lad_oe, 1'b0);
    check_now("R1 reset req", be_rd_req, 1'b0);
    check_now("R1 reset stb", be_wr_stb, 1'b0);
    @(negedge clk); rst_a_n = 1'b1;
    repeat (3) @(negedge clk);

    run_cycle(4'h6, 32'hFFF0_1234, 8'hC7, 1, 4'h0, 1, 0, "R5/R6 write");
    run_cycle(4'h6, 32'hFFFA_5A0F, 8'h18, 2, 4'h0, 1, 0, "R6 write b");
    run_cycle(4'h4, 32'hFFF7_0011, 8'h00, 1, 4'h0, 1, 0, "R7/R8/R12 read ready at once");
    run_cycle(4'h4, 32'hFFF0_00A2, 8'h00, 1, 4'h0, 1, 1, "R8/R12 read ready in turnaround");
    run_cycle(4'h4, 32'hFFF0_00B3, 8'h00, 1, 4'h0, 1, 3, "R8/R12 read with waits");
    run_cycle(4'h4, 32'hFFF0_00C4, 8'h00, 1, 4'h0, 1, MW + 1, "R9 ready on last wait");
    run_cycle(4'h4, 32'hFFF0_00D5, 8'h00, 1, 4'h0, 1, MW + 2, "R9 wait limit error");
    run_cycle(4'h6, 32'hFFF1_2345, 8'h99, 3, 4'h0, 1, 0, "R2 long frame ends 0000");
    run_cycle(4'h6, 32'hFFF1_2345, 8'h99, 3, 4'h5, 1, 0, "R2 long frame ends 0101");
    run_cycle(4'h4, 32'hFFF1_2345, 8'h00, 2, 4'h5, 1, 0, "R2 read bad start");
    run_cycle(4'h6, 32'hFFF2_0000, 8'h55, 1, 4'h0, 0, 0, "R3 write not selected");
    run_cycle(4'h4, 32'hFFF2_0000, 8'h00, 2, 4'h0, 0, 0, "R3 read not selected");
    run_cycle(4'h2, 32'hFFF3_0000, 8'h00, 1, 4'h0, 1, 0, "R4 unknown type");
    run_cycle(4'h7, 32'hFFF3_0000, 8'h00, 1, 4'h0, 1, 0, "R4 unknown type b");
    run_cycle(4'h6, 32'h0001_2345, 8'hEE, 1, 4'h0, 1, 0, "R11 write outside window");
    run_cycle(4'h4, 32'h0001_2345, 8'h00, 1, 4'h0, 1, 0, "R11 read outside window");

    // R10: abort a write in its address phase
    step(1'b1, 4'hF, 1'b0, 1'b0, mk(0, 0, 0, "R10 abort write"));
    step(1'b0, 4'h0, 1'b0, 1'b0, mk(0, 0, 0, "R10 abort write"));
    step(1'b1, 4'h6, 1'b0, 1'b0, mk(0, 0, 0, "R10 abort write"));
    for (int i = 0; i < 4; i++) step(1'b1, 4'hF, 1'b0, 1'b0, mk(0, 0, 0, "R10 abort write"));
    step(1'b0, 4'h0, 1'b0, 1'b0, mk(0, 0, 0, "R10 abort write"));
    step(1'b1, 4'hF, 1'b0, 1'b0, mk(0, 0, 0, "R10 abort write"));
    for (int i = 0; i < 6; i++) step(1'b1, 4'h3, 1'b0, 1'b0, mk(0, 0, 0, "R10 abort write"));

    // R10: abort a read while the target drives sync
    read_to_wait(32'hFFF4_4444, "R10 abort read");
    step(1'b0, 4'h0, 1'b0, 1'b0, mk(0, 0, 0, "R10 abort read"));
    step(1'b1, 4'hF, 1'b0, 1'b0, mk(0, 0, 0, "R10 abort read"));
    step(1'b1, 4'hF, 1'b0, 1'b0, mk(0, 0, 0, "R10 abort read"));
    run_cycle(4'h6, 32'hFFF4_5678, 8'h3A, 1, 4'h0, 1, 0, "R10 write after abort");

    // R1: second reset input mid-read releases the bus without a clock edge
    read_to_wait(32'hFFF5_5555, "R1 reset mid read");
    drain();
    rst_b_n = 1'b0;
    #1;
    check_now("R1 oe released at once", lad_oe, 1'b0);
    check_now("R1 req dropped at once", be_rd_req, 1'b0);
    repeat (2) @(negedge clk);
    rst_b_n = 1'b1;
    repeat (3) @(negedge clk);
    check_now("R1 idle after reset", lad_oe, 1'b0);
    run_cycle(4'h4, 32'hFFF6_0077, 8'h00, 1, 4'h0, 1, 2, "R1 read after reset");

    drain();
    summary();
    $finish;
  end

endmodule